// File: doc/BRIEF.md
# Two-Write Write-Once Cell Rewriting Codec

This block holds a 2-bit value in a group of three binary cells that can only be switched from 0 to 1 between erases. The value can change twice before an erase is needed. The first change uses a codeword with at most one set cell. The second change uses a codeword with two or three set cells. Every accepted update only adds set cells, so a single erase covers two updates.

The cell group lives inside the block. A write request carries new data, and the encoder works out the next cell pattern from the current one. The result is one of three outcomes:

- the cells are programmed, and a one-cycle write-enable marks the cycle;
- the write is skipped, because the data is already stored;
- the write is refused, and a sticky flag asks for an erase.

A read port always shows the decoded value of the cells. A generation counter reports how many programming steps have happened since the last erase. An erase input clears the cells, the counter and the flag in one clock.

Top module: `wom_rewrite_top`

## Requirements
- R1: After reset (active high, synchronous) the cells read 000, the read port shows 00, the generation is 0 and every flag output is low.
- R2: From the blank state 000, writing a value different from 00 programs the first-generation codeword in the next cycle: 01 gives 001, 10 gives 010, 11 gives 100 (bit 2 is the leftmost cell). The generation becomes 1 and the write-enable pulses high for one cycle.
- R3: From a first-generation state of weight 1, writing a different value programs the second-generation codeword, which is the complement of the first-generation one: 00 gives 111, 01 gives 110, 10 gives 101, 11 gives 011. The generation becomes 2 and never goes above 2.
- R4: The read port decodes by weight. A weight of 0 or 1 is looked up in the first-generation table (000 reads 00). A weight of 2 or 3 is looked up in the second-generation table.
- R5: A write whose data equals the value on the read port leaves the cells and the generation unchanged, and it gives no write-enable pulse.
- R6: A write of a different value to a state of weight 2 or more is refused. The cells stay as they are, and the erase-required flag rises in the next cycle and stays high until an erase or a reset.
- R7: Apart from an erase or a reset, no cell ever changes from 1 to 0.
- R8: An erase returns the cells to 000, the generation to 0 and the erase-required flag to low, all in the next cycle. It wins over a write requested in the same cycle.
- R9: The encoder checks that every next state contains all the set cells of the current state. If the check fails, a sticky error output is raised and the cells are left unchanged. For a correct codebook the error output stays low.
- R10: From the blank state, writing 10 and then 01 steps the cells 000, then 010, then 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_i | input | 1 | Clear the cell group and the generation counter |
| wr_req_i | input | 1 | Request to store wr_data_i |
| wr_data_i | input | 2 | Value to store |
| cells_o | output | 3 | Current cell pattern |
| rd_data_o | output | 2 | Decoded value of the cells |
| wr_en_o | output | 1 | One-cycle pulse after the cells were programmed |
| erase_req_o | output | 1 | Sticky: a write was refused and needs an erase first |
| gen_o | output | 2 | Programming steps since the last erase (0 to 2) |
| err_o | output | 1 | Sticky: the encoder produced a next state that would clear a cell |

## Verification
The hardest state to reach from the ports is a refused write. Getting there takes two programming steps with values that differ from each other and from the value already stored. If 00 is the first value, the blank state already holds it, so that write is skipped and uses up no generation. The stimulus therefore runs every ordered pair of first and second values from an erase. It then follows each pair with a repeat of the stored value and with a differing value. Sticky flags are watched through idle cycles until the next erase.

// File: rtl/wom_pkg.sv
package wom_pkg;

    localparam int DATA_W      = 2;
    localparam int CELL_W      = 3;
    localparam int GEN_W       = 2;
    localparam int MAX_GEN     = 2;
    localparam int NUM_VALUES  = 1 << DATA_W;
    localparam int SECOND_MIN  = (CELL_W + 1) / 2;

    typedef logic [CELL_W-1:0] cells_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [GEN_W-1:0]  gen_t;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_PROGRAM = 2'd1,
        ACT_REFUSE  = 2'd2
    } wr_action_e;

    typedef struct packed {
        cells_t     next;
        wr_action_e act;
        logic       viol;
    } enc_result_t;

    // one-hot code for nonzero values, all-clear for zero
    function automatic cells_t first_code(input data_t d);
        cells_t c;
        c = '0;
        if (d != '0) c = cells_t'(1) << (int'(d) - 1);
        return c;
    endfunction

    function automatic cells_t second_code(input data_t d);
        return ~first_code(d);
    endfunction

    function automatic int unsigned weight(input cells_t c);
        int unsigned w;
        w = 0;
        for (int i = 0; i < CELL_W; i++) w += int'(c[i]);
        return w;
    endfunction

endpackage

// File: rtl/wom_decoder.sv
module wom_decoder
    import wom_pkg::*;
(
    input  cells_t cells_i,
    output data_t  data_o,
    output logic   second_o,
    output logic   blank_o
);

    logic [NUM_VALUES-1:0] hit_first;
    logic [NUM_VALUES-1:0] hit_second;

    for (genvar g = 0; g < NUM_VALUES; g++) begin : g_book
        assign hit_first[g]  = (cells_i == first_code(data_t'(g)));
        assign hit_second[g] = (cells_i == second_code(data_t'(g)));
    end

    assign second_o = (weight(cells_i) >= SECOND_MIN);
    assign blank_o  = (cells_i == '0);

    always_comb begin
        data_o = '0;
        for (int k = 0; k < NUM_VALUES; k++) begin
            if (second_o ? hit_second[k] : hit_first[k]) data_o = data_t'(k);
        end
    end

endmodule

// File: rtl/wom_encoder.sv
module wom_encoder
    import wom_pkg::*;
(
    input  cells_t      cur_i,
    input  data_t       cur_data_i,
    input  logic        cur_second_i,
    input  logic        cur_blank_i,
    input  data_t       new_data_i,
    output enc_result_t res_o
);

    cells_t candidate;
    logic   superset_ok;

    always_comb begin
        candidate = cur_blank_i ? first_code(new_data_i) : second_code(new_data_i);
    end

    assign superset_ok = ((candidate & cur_i) == cur_i);

    always_comb begin
        res_o.next = cur_i;
        res_o.act  = ACT_HOLD;
        res_o.viol = 1'b0;
        if (new_data_i == cur_data_i) begin
            res_o.act = ACT_HOLD;
        end else if (cur_second_i) begin
            res_o.act = ACT_REFUSE;
        end else if (!superset_ok) begin
            res_o.viol = 1'b1;
        end else begin
            res_o.next = candidate;
            res_o.act  = ACT_PROGRAM;
        end
    end

endmodule

// File: rtl/wom_gen_tracker.sv
module wom_gen_tracker
    import wom_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic step_i,
    output gen_t gen_o
);

    gen_t gen_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            gen_q <= '0;
        end else if (step_i && (gen_q != gen_t'(MAX_GEN))) begin
            gen_q <= gen_q + gen_t'(1);
        end
    end

    assign gen_o = gen_q;

    // R3: the generation never passes its ceiling
    p_gen_cap_r3: assert property (@(posedge clk) disable iff (rst)
        gen_q <= gen_t'(MAX_GEN));

endmodule

// File: rtl/wom_rewrite_top.sv
module wom_rewrite_top
    import wom_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                erase_i,
    input  logic                wr_req_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [CELL_W-1:0]   cells_o,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                wr_en_o,
    output logic                erase_req_o,
    output logic [GEN_W-1:0]    gen_o,
    output logic                err_o
);

    cells_t      cells_q;
    data_t       rd_data;
    logic        is_second;
    logic        is_blank;
    enc_result_t enc;
    logic        wr_en_q;
    logic        ereq_q;
    logic        err_q;
    logic        do_write;
    logic        do_program;
    gen_t        gen;

    wom_decoder u_dec (
        .cells_i  (cells_q),
        .data_o   (rd_data),
        .second_o (is_second),
        .blank_o  (is_blank)
    );

    wom_encoder u_enc (
        .cur_i        (cells_q),
        .cur_data_i   (rd_data),
        .cur_second_i (is_second),
        .cur_blank_i  (is_blank),
        .new_data_i   (wr_data_i),
        .res_o        (enc)
    );

    assign do_write   = wr_req_i && !erase_i;
    assign do_program = do_write && (enc.act == ACT_PROGRAM);

    wom_gen_tracker u_gen (
        .clk     (clk),
        .rst     (rst),
        .clear_i (erase_i),
        .step_i  (do_program),
        .gen_o   (gen)
    );

    always_ff @(posedge clk) begin
        if (rst || erase_i) begin
            cells_q <= '0;
            wr_en_q <= 1'b0;
            ereq_q  <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (do_write) begin
                case (enc.act)
                    ACT_PROGRAM: begin
                        cells_q <= enc.next;
                        wr_en_q <= 1'b1;
                    end
                    ACT_REFUSE: ereq_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (do_write && enc.viol) begin
            err_q <= 1'b1;
        end
    end

    assign cells_o     = cells_q;
    assign rd_data_o   = rd_data;
    assign wr_en_o     = wr_en_q;
    assign erase_req_o = ereq_q;
    assign gen_o       = gen;
    assign err_o       = err_q;

    // R7: cells only gain set bits unless an erase is applied
    p_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        !erase_i |=> ((cells_q & $past(cells_q)) == $past(cells_q)));

    // R8: erase clears everything in one cycle
    p_erase_r8: assert property (@(posedge clk) disable iff (rst)
        erase_i |=> (cells_q == '0 && gen == '0 && !ereq_q));

    // R5: rewriting the stored value is a no-op
    p_same_r5: assert property (@(posedge clk) disable iff (rst)
        (do_write && wr_data_i == rd_data) |=> ($stable(cells_q) && !wr_en_q));

    // R6: differing write on a second-generation state is refused
    p_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        (do_write && is_second && wr_data_i != rd_data)
            |=> ($stable(cells_q) && ereq_q && !wr_en_q));

    // R2: the counter and the cells agree on the blank state
    p_blank_gen_r2: assert property (@(posedge clk) disable iff (rst)
        (gen == '0) |-> (cells_q == '0));

    // R3: after two steps the cells hold a heavy codeword
    p_heavy_gen_r3: assert property (@(posedge clk) disable iff (rst)
        (gen == gen_t'(MAX_GEN)) |-> (weight(cells_q) >= SECOND_MIN));

    // R9: the superset check never trips for this codebook
    p_no_viol_r9: assert property (@(posedge clk) disable iff (rst)
        !err_q);

endmodule

// File: tb/wom_rewrite_top_bench.sv
module wom_rewrite_top_bench;

    localparam int HALF = 2;
    localparam int WATCHDOG_NS = 200000 * 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       erase_i = 1'b0;
    logic       wr_req_i = 1'b0;
    logic [1:0] wr_data_i = 2'b00;
    logic [2:0] cells_o;
    logic [1:0] rd_data_o;
    logic       wr_en_o;
    logic       erase_req_o;
    logic [1:0] gen_o;
    logic       err_o;

    always #HALF clk = ~clk;

    wom_rewrite_top u_wom_rewrite_top (
        .clk         (clk),
        .rst         (rst),
        .erase_i     (erase_i),
        .wr_req_i    (wr_req_i),
        .wr_data_i   (wr_data_i),
        .cells_o     (cells_o),
        .rd_data_o   (rd_data_o),
        .wr_en_o     (wr_en_o),
        .erase_req_o (erase_req_o),
        .gen_o       (gen_o),
        .err_o       (err_o)
    );

    typedef struct {
        logic [2:0] cells;
        logic [1:0] rd;
        logic       wen;
        logic       ereq;
        logic [1:0] gen;
        logic       was_erase;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    // reference model state, built from the requirement tables
    logic [2:0] m_cells = 3'b000;
    logic [1:0] m_data  = 2'b00;
    logic [1:0] m_gen   = 2'd0;
    logic       m_ereq  = 1'b0;

    function automatic logic [2:0] tb_first(input logic [1:0] d);
        case (d)
            2'd0: return 3'b000;
            2'd1: return 3'b001;
            2'd2: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] tb_second(input logic [1:0] d);
        case (d)
            2'd0: return 3'b111;
            2'd1: return 3'b110;
            2'd2: return 3'b101;
            default: return 3'b011;
        endcase
    endfunction

    function automatic int tb_weight(input logic [2:0] c);
        return int'(c[0]) + int'(c[1]) + int'(c[2]);
    endfunction

    task automatic op(input bit er, input bit wr, input logic [1:0] d, input string tag);
        exp_t e;
        logic wen;
        @(negedge clk);
        erase_i   = er;
        wr_req_i  = wr;
        wr_data_i = d;
        wen = 1'b0;
        if (er) begin
            m_cells = 3'b000; m_data = 2'b00; m_gen = 2'd0; m_ereq = 1'b0;
        end else if (wr && d != m_data) begin
            if (tb_weight(m_cells) >= 2) begin
                m_ereq = 1'b1;
            end else begin
                m_cells = (m_cells == 3'b000) ? tb_first(d) : tb_second(d);
                m_data  = d;
                m_gen   = m_gen + 2'd1;
                wen     = 1'b1;
            end
        end
        e.cells = m_cells; e.rd = m_data; e.wen = wen; e.ereq = m_ereq;
        e.gen = m_gen; e.was_erase = er; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        erase_i  = 1'b0;
        wr_req_i = 1'b0;
    endtask

    // monitor: compares each result one time unit after the edge that made it
    initial begin
        logic [2:0] prev;
        prev = 3'b000;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (cells_o !== e.cells || rd_data_o !== e.rd || wr_en_o !== e.wen ||
                    erase_req_o !== e.ereq || gen_o !== e.gen || err_o !== 1'b0) begin
                    bad++;
                    $display("FAIL %s: actual cells=%b rd=%b wen=%b ereq=%b gen=%0d err=%b expected cells=%b rd=%b wen=%b ereq=%b gen=%0d err=0",
                             e.tag, cells_o, rd_data_o, wr_en_o, erase_req_o, gen_o, err_o,
                             e.cells, e.rd, e.wen, e.ereq, e.gen);
                end
                total++;
                if (!e.was_erase && ((cells_o & prev) !== prev)) begin
                    bad++;
                    $display("FAIL R7 cell cleared: actual cells=%b expected superset of %b", cells_o, prev);
                end
                prev = cells_o;
            end
        end
    end

    initial begin
        #(WATCHDOG_NS);
        if (!finished) begin
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        op(0, 0, 2'd0, "R1 reset state");

        // R10 reference sequence
        op(1, 0, 2'd0, "R8 erase");
        op(0, 1, 2'd2, "R10 step to 010 / R2");
        op(0, 1, 2'd1, "R10 step to 110 / R3");
        op(0, 0, 2'd0, "R4 idle read of 110");

        // every ordered pair of first and second values
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                op(1, 0, 2'd0, "R8 erase before pair");
                op(0, 1, 2'(a), "R2 first write");
                op(0, 1, 2'(b), "R3 second write");
                op(0, 1, 2'(b), "R5 repeat stored value");
                op(0, 1, 2'(b + 1), "R6 differing write");
                op(0, 0, 2'd0, "R6 flag held idle / R4 read");
            end
        end

        // third generation from a first-gen state reached after blank 00
        op(1, 0, 2'd0, "R8 erase");
        op(0, 1, 2'd0, "R5 write 00 on blank");
        op(0, 1, 2'd3, "R2 write 11");
        op(0, 1, 2'd0, "R3 write 00 gives 111");
        op(0, 1, 2'd1, "R6 refused on 111");
        op(1, 1, 2'd2, "R8 erase wins over write");
        op(0, 0, 2'd0, "R8 state after erase");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule